// File: doc/BRIEF.md
# DRAM Write Thermal Throttle Controller

This block watches the stream of QWords written to DRAM and holds that traffic down when it runs hot. The watching has two levels. A long sampling window, counted in millisecond ticks, gathers the total QWords written. If that total reaches a programmed threshold, the block enters a throttling state that lasts a programmed number of sampling windows. While it throttles, a short monitoring window counted in DRAM clocks meters the writes. Once the budget for the current short window is used up, a block output stops further writes until that window ends.

All settings come from one 64-bit control word, written through byte lanes. A sticky lock bit in this word freezes the whole word and is also brought out so that a companion read-side register can follow it. Only reset releases the lock. Monitoring runs only under one particular mode code. Any other code keeps the counters clear and holds both outputs low.

Top module: `dram_wr_throttle`

## Requirements
- R1: After reset the control word reads back as all zeros, and `cfg_locked`, `throttle_active` and `wr_block` are low.
- R2: A write with strobe bit i set loads bits 8i+7..8i of the control word, and lanes whose strobe bit is clear keep their value. Bits 62:46 are reserved, are never stored and always read as zero.
- R3: Bit 63 is the lock. Once it is set, `cfg_locked` is high and every later write is ignored, so the read-back value does not change. Only reset clears the lock.
- R4: Bits 2:0 are the mode field, and monitoring runs only when it equals 100b. Under any other code the global and monitoring counters are held clear, and `throttle_active` and `wr_block` are low in the same cycle the code takes effect.
- R5: Bits 45:38 set the sampling window, whose length is this value times WIN_MULT millisecond ticks (default 4). The global QWord count clears at every window boundary.
- R6: Bits 37:26 set the threshold, which is this value shifted left by THR_SHIFT. Throttling begins on the clock edge after the global count reaches the threshold. A threshold field of zero, or a window field of zero, never starts throttling.
- R7: Bits 25:20 set the throttle time. Throttling ends at the N-th sampling-window boundary after it starts, where N is this value; the partly elapsed window counts as the first. A value of zero never starts throttling.
- R8: Bits 19:13 set the monitoring window, whose length is this value times 16 DRAM clocks. The first window begins in the first cycle of throttling. Within each window `wr_block` goes high once the window's QWord count reaches the budget in bits 12:3, and stays high until the window ends. A budget of zero blocks for the whole window.
- R9: A monitoring-window field of zero means `wr_block` never asserts, even while throttling.
- R10: The global QWord count saturates at its all-ones value and does not wrap.
- R11: `wr_block` is high only while `throttle_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_strb | input | 8 | Byte-lane enables for the write |
| cfg_wr_data | input | 64 | Write data |
| cfg_rd_data | output | 64 | Current control word |
| cfg_locked | output | 1 | Lock state, shared with the companion read-throttle register |
| qw_in | input | QW_IN_W | QWords written to DRAM in this cycle |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| wr_block | output | 1 | Hold off further DRAM writes |
| throttle_active | output | 1 | Throttling state in effect |

## Verification
Two behaviours can land in the same cycle: a write that drops the mode code, and the monitoring meter holding `wr_block` high in the middle of a throttle. The bench provokes this by using a zero budget, so that blocking is continuous. It then writes a non-running mode code while the block is asserted. At the next sample both outputs must be low, which shows that the mode gate wins over the meter's registered state. A second case is a throttle that starts in the middle of a sampling window. The bench judges it by the exact tick count at which throttling drops, which shows that the partial window counts toward the throttle time.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int REG_W   = 64;
    localparam int LANES   = REG_W / 8;
    localparam int SW_W    = 8;
    localparam int GQ_W    = 12;
    localparam int TT_W    = 6;
    localparam int TMW_W   = 7;
    localparam int TQM_W   = 10;
    localparam int MODE_W  = 3;
    localparam int RSVD_W  = REG_W - 1 - SW_W - GQ_W - TT_W - TMW_W - TQM_W - MODE_W;

    localparam logic [MODE_W-1:0] MODE_RUN = 3'b100;

    // bits that hold state: lock (63) and fields 45:0
    localparam logic [REG_W-1:0] STORE_MASK = 64'h8000_3FFF_FFFF_FFFF;

    typedef struct packed {
        logic                 lock;
        logic [RSVD_W-1:0]    rsvd;
        logic [SW_W-1:0]      win;
        logic [GQ_W-1:0]      gq;
        logic [TT_W-1:0]      tt;
        logic [TMW_W-1:0]     tmw;
        logic [TQM_W-1:0]     tqm;
        logic [MODE_W-1:0]    mode;
    } dwt_cfg_t;

    function automatic logic mode_runs(input dwt_cfg_t c);
        return c.mode == MODE_RUN;
    endfunction

endpackage

// File: rtl/dwt_cfg_reg.sv
module dwt_cfg_reg
    import dwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_strb,
    input  logic [REG_W-1:0] wr_data,
    output dwt_cfg_t         cfg,
    output logic             locked
);

    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] word_d;
    logic [REG_W-1:0] bit_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bit_en[8*i +: 8] = {8{wr_en & wr_strb[i] & ~word_q[REG_W-1]}};
    end

    always_comb begin
        word_d = ((word_q & ~bit_en) | (wr_data & bit_en)) & STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign cfg    = dwt_cfg_t'(word_q);
    assign locked = word_q[REG_W-1];

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(word_q)); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R3

endmodule

// File: rtl/dwt_global_mon.sv
module dwt_global_mon
    import dwt_pkg::*;
#(
    parameter int THR_SHIFT = 15,
    parameter int WIN_MULT  = 4,
    parameter int QW_IN_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SW_W-1:0]    win,
    input  logic [GQ_W-1:0]    gq,
    input  logic [TT_W-1:0]    tt,
    input  logic [QW_IN_W-1:0] qw_in,
    input  logic               ms_tick,
    output logic               active
);

    localparam int CNT_W = GQ_W + THR_SHIFT;
    localparam int MS_W  = $clog2(((1 << SW_W) - 1) * WIN_MULT + 1);

    logic [MS_W-1:0]  ms_cnt;
    logic [MS_W-1:0]  win_len;
    logic [MS_W-1:0]  win_last;
    logic             win_on;
    logic             bound;
    logic [CNT_W-1:0] qcnt;
    logic [CNT_W:0]   qsum;
    logic [CNT_W-1:0] thr;
    logic             hit;
    logic [TT_W-1:0]  remain;

    assign win_len  = MS_W'(win) * MS_W'(WIN_MULT);
    assign win_last = win_len - MS_W'(1);
    assign win_on   = win != '0;
    assign bound    = en && win_on && ms_tick && (ms_cnt >= win_last);
    assign qsum     = {1'b0, qcnt} + (CNT_W+1)'(qw_in);
    assign thr      = {gq, {THR_SHIFT{1'b0}}};
    assign hit      = en && win_on && (gq != '0) && (tt != '0) && (qcnt >= thr);

    always_ff @(posedge clk) begin
        if (rst || !en || !win_on)  ms_cnt <= '0;
        else if (bound)             ms_cnt <= '0;
        else if (ms_tick)           ms_cnt <= ms_cnt + MS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !en)      qcnt <= '0;
        else if (bound)      qcnt <= '0;
        else if (qsum[CNT_W]) qcnt <= '1;
        else                 qcnt <= qsum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            remain <= '0;
        end else if (!active) begin
            if (hit) begin
                active <= 1'b1;
                remain <= tt;
            end
        end else if (bound) begin
            if (remain <= TT_W'(1)) begin
                active <= 1'b0;
                remain <= '0;
            end else begin
                remain <= remain - TT_W'(1);
            end
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && !bound) |=> (qcnt >= $past(qcnt))); // R10
    AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (rst)
        active |-> (remain != '0)); // R7
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!active && qcnt == '0)); // R4

endmodule

// File: rtl/dwt_win_meter.sv
module dwt_win_meter
    import dwt_pkg::*;
#(
    parameter int QW_IN_W   = 3,
    parameter int TMW_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [TMW_W-1:0]   tmw,
    input  logic [TQM_W-1:0]   tqm,
    input  logic [QW_IN_W-1:0] qw_in,
    output logic               block
);

    localparam int WL_W = TMW_W + TMW_SHIFT;
    localparam int WQ_W = TQM_W + 1;

    logic [WL_W-1:0] win_len;
    logic [WL_W-1:0] wcnt;
    logic            run;
    logic            win_end;
    logic [WQ_W-1:0] wq;
    logic [WQ_W:0]   wsum;

    assign win_len = {tmw, {TMW_SHIFT{1'b0}}};
    assign run     = active && (tmw != '0);
    assign win_end = wcnt >= win_len - WL_W'(1);
    assign wsum    = {1'b0, wq} + (WQ_W+1)'(qw_in);

    always_ff @(posedge clk) begin
        if (rst || !run)  wcnt <= '0;
        else if (win_end) wcnt <= '0;
        else              wcnt <= wcnt + WL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)   wq <= '0;
        else if (win_end)  wq <= '0;
        else if (wsum[WQ_W]) wq <= '1;
        else               wq <= wsum[WQ_W-1:0];
    end

    assign block = run && (wq >= WQ_W'(tqm));

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (wcnt < win_len)); // R8
    AST_WIN_FRESH: assert property (@(posedge clk) disable iff (rst)
        (run && win_end) |=> (wq == '0)); // R8
    AST_BLOCK_GATED: assert property (@(posedge clk) disable iff (rst)
        block |-> active); // R11

endmodule

// File: rtl/dram_wr_throttle.sv
module dram_wr_throttle
    import dwt_pkg::*;
#(
    parameter int THR_SHIFT = 15,
    parameter int WIN_MULT  = 4,
    parameter int QW_IN_W   = 3,
    parameter int TMW_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic [7:0]         cfg_wr_strb,
    input  logic [63:0]        cfg_wr_data,
    output logic [63:0]        cfg_rd_data,
    output logic               cfg_locked,
    input  logic [QW_IN_W-1:0] qw_in,
    input  logic               ms_tick,
    output logic               wr_block,
    output logic               throttle_active
);

    dwt_cfg_t cfg;
    logic     en;
    logic     act;
    logic     blk;

    dwt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_strb (cfg_wr_strb),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .locked  (cfg_locked)
    );

    assign en = mode_runs(cfg);

    dwt_global_mon #(
        .THR_SHIFT (THR_SHIFT),
        .WIN_MULT  (WIN_MULT),
        .QW_IN_W   (QW_IN_W)
    ) u_glob (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .win     (cfg.win),
        .gq      (cfg.gq),
        .tt      (cfg.tt),
        .qw_in   (qw_in),
        .ms_tick (ms_tick),
        .active  (act)
    );

    dwt_win_meter #(
        .QW_IN_W   (QW_IN_W),
        .TMW_SHIFT (TMW_SHIFT)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .active (act),
        .tmw    (cfg.tmw),
        .tqm    (cfg.tqm),
        .qw_in  (qw_in),
        .block  (blk)
    );

    assign cfg_rd_data     = cfg;
    assign throttle_active = act & en;
    assign wr_block        = blk & en;

    AST_BLOCK_NEEDS_THR: assert property (@(posedge clk) disable iff (rst)
        wr_block |-> throttle_active); // R11
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[62:46] == '0); // R2

endmodule

// File: tb/tb_dram_wr_throttle.sv
module tb_dram_wr_throttle;

    localparam int TSH = 4;

    typedef struct packed {
        logic [7:0]  win;
        logic [11:0] gq;
        logic [2:0]  qw;
        logic [15:0] n;
        logic        exp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{8'd1, 12'd1, 3'd4, 16'd4,  1'b1},
        '{8'd1, 12'd1, 3'd5, 16'd3,  1'b0},
        '{8'd1, 12'd2, 3'd3, 16'd11, 1'b1},
        '{8'd1, 12'd2, 3'd3, 16'd10, 1'b0},
        '{8'd1, 12'd3, 3'd7, 16'd7,  1'b1},
        '{8'd1, 12'd0, 3'd7, 16'd20, 1'b0},
        '{8'd0, 12'd1, 3'd7, 16'd20, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_strb = '0;
    logic [63:0] cfg_wr_data = '0;
    logic [63:0] cfg_rd_data;
    logic        cfg_locked;
    logic [2:0]  qw_in = '0;
    logic        ms_tick = 1'b0;
    logic        wr_block;
    logic        throttle_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dram_wr_throttle #(.THR_SHIFT(TSH)) dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_wr_strb     (cfg_wr_strb),
        .cfg_wr_data     (cfg_wr_data),
        .cfg_rd_data     (cfg_rd_data),
        .cfg_locked      (cfg_locked),
        .qw_in           (qw_in),
        .ms_tick         (ms_tick),
        .wr_block        (wr_block),
        .throttle_active (throttle_active)
    );

    function automatic logic [63:0] mk(input logic lk, input logic [7:0] win,
                                       input logic [11:0] gq, input logic [5:0] tt,
                                       input logic [6:0] tmw, input logic [9:0] tqm,
                                       input logic [2:0] mode);
        return {lk, 17'd0, win, gq, tt, tmw, tqm, mode};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] strb, input logic [63:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_strb = strb; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_strb = '0;
    endtask

    task automatic run_qw(input logic [2:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            qw_in = v;
            @(negedge clk);
        end
        qw_in = '0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear();
        wr(8'h7F, 64'd0);
    endtask

    task automatic meter_run(input logic [9:0] tqm, output int blocked, output logic seen);
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd1, 7'd1, tqm, 3'b100));
        chk("R11 no block before throttle", {63'd0, wr_block}, 64'd0);
        qw_in = 3'd7;
        for (int k = 0; k < 20 && !throttle_active; k++) @(negedge clk);
        seen = throttle_active;
        blocked = 0;
        for (int i = 0; i < 160; i++) begin
            blocked += int'(wr_block);
            qw_in = wr_block ? 3'd0 : 3'd1;
            @(negedge clk);
        end
        qw_in = '0;
    endtask

    initial begin
        int   blocked;
        logic seen;
        logic [63:0] lk_val;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 readback", cfg_rd_data, 64'd0);
        chk("R1 outputs", {61'd0, cfg_locked, throttle_active, wr_block}, 64'd0);

        // R2 byte lanes and reserved bits
        wr(8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 lanes 0-6 set, reserved zero", cfg_rd_data, 64'h0000_3FFF_FFFF_FFFF);
        wr(8'h05, 64'd0);
        chk("R2 lanes 0 and 2 cleared", cfg_rd_data, 64'h0000_3FFF_FF00_FF00);

        // R6 threshold vectors
        foreach (VEC[i]) begin
            clear();
            wr(8'h7F, mk(0, VEC[i].win, VEC[i].gq, 6'd1, 7'd0, 10'd0, 3'b100));
            run_qw(VEC[i].qw, int'(VEC[i].n));
            idle(2);
            chk($sformatf("R6 vector %0d", i), {63'd0, throttle_active}, {63'd0, VEC[i].exp});
            chk($sformatf("R9 vector %0d", i), {63'd0, wr_block}, 64'd0);
        end

        // R5 global window clears the count
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd1, 7'd0, 10'd0, 3'b100));
        run_qw(3'd5, 3);
        repeat (4) tick();
        run_qw(3'd5, 3);
        idle(2);
        chk("R5 count cleared at boundary", {63'd0, throttle_active}, 64'd0);
        run_qw(3'd1, 1);
        idle(2);
        chk("R6 exact threshold", {63'd0, throttle_active}, 64'd1);

        // R7 throttle duration
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd2, 7'd0, 10'd0, 3'b100));
        run_qw(3'd7, 3);
        idle(2);
        chk("R7 started", {63'd0, throttle_active}, 64'd1);
        repeat (7) tick();
        chk("R7 held before second boundary", {63'd0, throttle_active}, 64'd1);
        tick();
        chk("R7 ended at second boundary", {63'd0, throttle_active}, 64'd0);

        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd0, 7'd0, 10'd0, 3'b100));
        run_qw(3'd7, 5);
        idle(2);
        chk("R7 zero time never starts", {63'd0, throttle_active}, 64'd0);

        // R10 saturation
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd4095, 6'd0, 7'd0, 10'd0, 3'b100));
        run_qw(3'd7, 10000);
        wr(8'h7F, mk(0, 8'd1, 12'd4095, 6'd1, 7'd0, 10'd0, 3'b100));
        idle(2);
        chk("R10 saturated count stays above threshold", {63'd0, throttle_active}, 64'd1);

        // R8 metering
        meter_run(10'd3, blocked, seen);
        chk("R8 throttle seen", {63'd0, seen}, 64'd1);
        chk("R8 blocked cycles budget 3", 64'(blocked), 64'd130);
        meter_run(10'd0, blocked, seen);
        chk("R8 zero budget blocks all", 64'(blocked), 64'd160);

        // R4 mode drop while blocking
        wr(8'h01, 64'd0);
        chk("R4 outputs drop with mode", {62'd0, throttle_active, wr_block}, 64'd0);

        // R4 reserved mode code
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd1, 7'd1, 10'd0, 3'b101));
        run_qw(3'd7, 10);
        idle(2);
        chk("R4 reserved mode idle", {62'd0, throttle_active, wr_block}, 64'd0);

        // R9 zero monitoring window while throttling
        clear();
        wr(8'h7F, mk(0, 8'd1, 12'd1, 6'd1, 7'd0, 10'd0, 3'b100));
        run_qw(3'd7, 3);
        idle(20);
        chk("R9 throttling, no block", {62'd0, throttle_active, wr_block}, 64'd2);

        // R3 lock
        lk_val = mk(1, 8'd5, 12'd7, 6'd3, 7'd2, 10'd9, 3'b100);
        wr(8'hFF, lk_val);
        chk("R3 lock readback", cfg_rd_data, lk_val);
        chk("R3 locked flag", {63'd0, cfg_locked}, 64'd1);
        wr(8'hFF, 64'd0);
        chk("R3 write ignored", cfg_rd_data, lk_val);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        chk("R3 reset unlocks", {cfg_rd_data[63:1], cfg_locked}, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule